// File: doc/BRIEF.md
# DMA Global Control and Peripheral Request Router

This block is the global control front of a four-channel peripheral DMA controller. It is reached over a simple 32-bit register bus with write strobe, read strobe, byte address and data. It holds a per-channel clock enable mask and a software reset that clears itself. It also holds a selection register that steers eight peripheral DMA request lines onto the four channel request inputs. A read-only register summarises the four channel interrupt lines.

The eight peripheral request lines are SPI receive, SPI transmit, ADC receive, PWM transmit, UART receive, UART transmit, I2S receive and I2S transmit. Receive requests ask a channel to use the peripheral as the transfer source. Transmit requests ask it to use the peripheral as the destination. The router does not depend on direction. Each request has a 4-bit selector naming the channel it drives. The software reset is a four-cycle pulse to the channel engines. It leaves every programmed register unchanged. The channel engines, bus masters and peripherals sit outside this block and are seen only through its ports.

Top module: `dmac_route_ctrl`

## Requirements
- R1: After reset, chan_clk_en, chan_req and chan_soft_rst are 0. Reads of the control register at offset 0x0 and the selection register at offset 0x4 return 0.
- R2: A write to offset 0x0 with bit 0 set drives chan_soft_rst high for exactly 4 cycles, starting in the cycle after the write. A write there with bit 0 clear starts no pulse.
- R3: The reset pulse does not change the clock enable mask or the selection register.
- R4: Bit 0 of a read at offset 0x0 returns 1 while chan_soft_rst is high and 0 otherwise.
- R5: Bits 11:8 of offset 0x0 are written into chan_clk_en, with bit 8+n enabling channel n. They read back at the same position.
- R6: Offset 0x4 holds eight 4-bit selectors. Selector p occupies bits 4p+3:4p and steers periph_req[p]. Index p runs 0 SPI rx, 1 SPI tx, 2 ADC rx, 3 PWM tx, 4 UART rx, 5 UART tx, 6 I2S rx, 7 I2S tx. chan_req[c] is the OR of every periph_req[p] whose selector equals c. It is combinational from periph_req, and the selector takes effect the cycle after it is written.
- R7: A selector value from 4 to 15 steers its request to no channel.
- R8: chan_req[c] is 0 whenever chan_clk_en[c] is 0.
- R9: A read at offset 0xC returns chan_irq in bits 3:0 and 0 above. Writes to 0xC change nothing.
- R10: Reads of unused bits, of offset 0x8 and of any offset that is not a multiple of 4 return 0. Writes to those offsets have no effect. bus_rdata is 0 when bus_rd is low.
- R11: A write of bit 0 = 1 during an active pulse restarts it, so chan_soft_rst stays high for 4 cycles after the latest such write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during bus_rd |
| periph_req | input | 8 | Peripheral DMA requests, indexed as in R6 |
| chan_irq | input | 4 | Channel interrupt lines |
| chan_req | output | 4 | Routed and gated channel requests |
| chan_clk_en | output | 4 | Per-channel clock enables |
| chan_soft_rst | output | 1 | Software reset pulse to all channels |

## Verification
Two functions can fall in the same cycle. One is a single control write that both changes the clock enable mask and starts the reset pulse. The other is a second reset write that lands while a pulse is still running. Both are provoked by directed writes. The first is judged on three points: the new enables are live during the pulse, routed requests follow them, and the pulse lasts 4 cycles. The second is judged by counting high cycles from the restarting write. Random selector, enable and request patterns are then compared against a bench model of the router.

// File: rtl/dmac_route_pkg.sv
package dmac_route_pkg;
    parameter int NCHAN     = 4;
    parameter int NPERIPH   = 8;
    parameter int SEL_W     = 4;
    parameter int DATA_W    = 32;
    parameter int ADDR_W    = 4;
    parameter int PULSE_LEN = 4;
    parameter int EN_LSB    = 8;
    localparam int CNT_W    = $clog2(PULSE_LEN + 1);
    localparam int SELS_W   = NPERIPH * SEL_W;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_SEL  = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_IRQ  = 4'hC;

    typedef struct packed {
        logic [NCHAN-1:0]  en;
        logic [SELS_W-1:0] sel;
        logic [CNT_W-1:0]  cnt;
    } regs_t;
endpackage

// File: rtl/dmac_route_regs.sv
module dmac_route_regs
    import dmac_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NCHAN-1:0]  irq,
    output logic [DATA_W-1:0] rdata,
    output logic [NCHAN-1:0]  en,
    output logic [SELS_W-1:0] sel,
    output logic              soft_rst
);
    regs_t r_d, r_q;
    logic  pulse_on;

    assign pulse_on = (r_q.cnt != '0);

    always_comb begin
        r_d = r_q;
        if (pulse_on) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
        if (wr && addr == OFF_CTRL) begin
            r_d.en = wdata[EN_LSB +: NCHAN];
            if (wdata[0]) begin
                r_d.cnt = CNT_W'(PULSE_LEN);
            end
        end
        if (wr && addr == OFF_SEL) begin
            r_d.sel = wdata[SELS_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                OFF_CTRL: begin
                    rdata[0]               = pulse_on;
                    rdata[EN_LSB +: NCHAN] = r_q.en;
                end
                OFF_SEL: rdata[SELS_W-1:0] = r_q.sel;
                OFF_IRQ: rdata[NCHAN-1:0]  = irq;
                default: rdata = '0;
            endcase
        end
    end

    assign en       = r_q.en;
    assign sel      = r_q.sel;
    assign soft_rst = pulse_on;

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFF_CTRL && wdata[0]) |=> soft_rst); // R2

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst) |-> $past(wr && addr == OFF_CTRL && wdata[0])); // R2

    AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !wr) |=> ($stable(en) && $stable(sel))); // R3

    AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr != OFF_CTRL && addr != OFF_SEL) |=> ($stable(en) && $stable(sel))); // R10

    AST_IRQ_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == OFF_IRQ) |-> (rdata[DATA_W-1:NCHAN] == '0)); // R9
endmodule

// File: rtl/dmac_route_xbar.sv
module dmac_route_xbar
    import dmac_route_pkg::*;
(
    input  logic [NPERIPH-1:0] preq,
    input  logic [SELS_W-1:0]  sel,
    input  logic [NCHAN-1:0]   en,
    output logic [NCHAN-1:0]   creq
);
    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int p = 0; p < NPERIPH; p++) begin
                if (preq[p] && sel[p*SEL_W +: SEL_W] == SEL_W'(c)) begin
                    hit = 1'b1;
                end
            end
        end
        assign creq[c] = hit & en[c];
    end
endmodule

// File: rtl/dmac_route_ctrl.sv
module dmac_route_ctrl
    import dmac_route_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NPERIPH-1:0] periph_req,
    input  logic [NCHAN-1:0]   chan_irq,
    output logic [NCHAN-1:0]   chan_req,
    output logic [NCHAN-1:0]   chan_clk_en,
    output logic               chan_soft_rst
);
    logic [SELS_W-1:0] sel;

    dmac_route_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .irq      (chan_irq),
        .rdata    (bus_rdata),
        .en       (chan_clk_en),
        .sel      (sel),
        .soft_rst (chan_soft_rst)
    );

    dmac_route_xbar u_xbar (
        .preq (periph_req),
        .sel  (sel),
        .en   (chan_clk_en),
        .creq (chan_req)
    );

    AST_GATED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_req & ~chan_clk_en) == '0); // R8
endmodule

// File: tb/dmac_route_ctrl_test.sv
module dmac_route_ctrl_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  periph_req = '0;
    logic [3:0]  chan_irq = '0;
    logic [3:0]  chan_req, chan_clk_en;
    logic        chan_soft_rst;

    int tests = 0, fails = 0;

    always #(PERIOD/2) clk = ~clk;

    dmac_route_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .periph_req(periph_req), .chan_irq(chan_irq), .chan_req(chan_req),
        .chan_clk_en(chan_clk_en), .chan_soft_rst(chan_soft_rst)
    );

    function automatic logic [3:0] model_req(logic [31:0] s, logic [3:0] e, logic [7:0] r);
        logic [3:0] o = '0;
        for (int p = 0; p < 8; p++) begin
            if (r[p] && s[4*p +: 4] < 4) o[s[4*p +: 2]] = 1'b1;
        end
        return o & e;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic count_pulse(output int n, output logic first);
        n = 0;
        first = chan_soft_rst;
        for (int i = 0; i < 7; i++) begin
            if (chan_soft_rst) n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d, s;
        logic [3:0]  e;
        logic        f;
        int          n;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        periph_req = 8'hFF;
        #1;
        check("R1 outs", {chan_clk_en, chan_req, 3'b0, chan_soft_rst}, 32'h0);
        rd(4'h0, d); check("R1 ctrl", d, 32'h0);
        rd(4'h4, d); check("R1 sel", d, 32'h0);
        periph_req = '0;

        // R5 enables and readback
        wr(4'h0, 32'h0000_0A00);
        check("R5 en", chan_clk_en, 4'hA);
        rd(4'h0, d); check("R5 rb", d, 32'h0000_0A00);
        check("R2 no pulse on 0", chan_soft_rst, 1'b0);

        // R6 specific routing: SPI rx->3, UART tx->1, others parked at 15
        s = 32'hFF1F_FFF3;
        wr(4'h4, s);
        wr(4'h0, 32'h0000_0F00);
        rd(4'h4, d); check("R6 sel rb", d, s);
        periph_req = 8'b0000_0001; #1 check("R6 spi rx", chan_req, 4'b1000);
        periph_req = 8'b0010_0000; #1 check("R6 uart tx", chan_req, 4'b0010);
        periph_req = 8'b1101_1110; #1 check("R7 parked", chan_req, 4'b0000);
        periph_req = '0;

        // R2 R3 R4 plain pulse
        wr(4'h0, 32'h0000_0F01);
        rd(4'h0, d); check("R4 bit0 during", d, 32'h0000_0F01);
        count_pulse(n, f);
        check("R2 first", f, 1'b1);
        check("R2 length", n, 4);
        rd(4'h0, d); check("R4 bit0 after", d, 32'h0000_0F00);
        rd(4'h4, d); check("R3 sel kept", d, s);
        check("R3 en kept", chan_clk_en, 4'hF);

        // same-cycle: enable change with pulse start (R5, R8 during R2)
        wr(4'h0, 32'h0000_0601);
        check("R5 en with pulse", chan_clk_en, 4'h6);
        periph_req = 8'b0010_0001; #1
        check("R8 gated in pulse", chan_req, 4'b0010);
        periph_req = '0;
        count_pulse(n, f);
        check("R2 length combo", n, 4);

        // R11 restart during pulse
        wr(4'h0, 32'h0000_0F01);
        @(negedge clk);
        wr(4'h0, 32'h0000_0F01);
        count_pulse(n, f);
        check("R11 restart", n, 4);

        // R9 irq readback, write ignored
        chan_irq = 4'h5; rd(4'hC, d); check("R9 irq", d, 32'h5);
        chan_irq = 4'hA; rd(4'hC, d); check("R9 irq2", d, 32'hA);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'h0, d); check("R9 wr ignored ctrl", d, 32'h0000_0F00);
        rd(4'h4, d); check("R9 wr ignored sel", d, s);

        // R10 unmapped
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'h1, 32'hFFFF_FFFF);
        wr(4'h6, 32'h0000_0000);
        rd(4'h8, d); check("R10 rd 8", d, 32'h0);
        rd(4'h2, d); check("R10 rd 2", d, 32'h0);
        rd(4'h0, d); check("R10 ctrl kept", d, 32'h0000_0F00);
        rd(4'h4, d); check("R10 sel kept", d, s);
        check("R10 no pulse", chan_soft_rst, 1'b0);
        bus_addr = 4'h4; #1 check("R10 idle rdata", bus_rdata, 32'h0);

        // random routing
        for (int k = 0; k < 300; k++) begin
            s = $urandom;
            for (int p = 0; p < 8; p++) if ($urandom_range(3) != 0) s[4*p+2 +: 2] = 2'b00;
            e = 4'($urandom);
            wr(4'h4, s);
            wr(4'h0, {20'h0, e, 8'h0});
            for (int j = 0; j < 3; j++) begin
                periph_req = 8'($urandom);
                #1 check("R6 R7 R8 random", chan_req, model_req(s, e, periph_req));
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule